// File: doc/BRIEF.md
# NAND Flash Block Erase Sequencer

This block sits on the host side of a parallel 8-bit NAND flash bus and performs one block erase per request. A pulse on `start` latches a block number. The sequencer then drives chip-enable and the latch strobes through four write bus cycles: the erase setup opcode, two block-address bytes and the confirm opcode. It then waits for the device's ready/busy line. When the device is ready again, it reads the status byte. Every write, address and read strobe is shaped by counters that give a fixed number of clock cycles of setup, active pulse and hold.

While the device is busy, a counter limits how long the sequencer waits. If ready/busy stays low past that limit, the operation is abandoned without a status read and a timeout is reported. Each request ends with a one-cycle `done` pulse, together with a pass flag and a timeout flag. The caller may issue the next request in the same cycle that `done` is high.

The host side is kept minimal: a request, a block number and three result signals. Opcodes are fixed inside the block. Only bus timing and the busy limit are parameters.

Top module: `nand_erase_seq`

## Requirements
- R1: `start` is accepted only while `busy` is low. `busy` is high from the cycle after acceptance until the cycle `done` pulses. A `start` seen while `busy` is high has no effect on the bytes sent or on the result.
- R2: Exactly four write bus cycles are sent, in this order: opcode 60h, address byte one, address byte two, opcode D0h. After a successful busy wait, one more write cycle carries opcode 70h.
- R3: The block number `block_addr` (width 3+LAST_BITS) is mapped onto the two address bytes as follows. Byte one carries `block_addr[2:0]` on data bits 7..5, with bits 4..0 zero. Byte two carries `block_addr[BLK_W-1:3]` on data bits LAST_BITS-1..0. All higher bits of byte two, including bits 7..2 at the default width, are zero.
- R4: Opcode cycles drive the command latch high and the address latch low. Address cycles drive the address latch high and the command latch low. The two latches are never high together.
- R5: After the confirm opcode, the sequencer waits T_WB cycles and then waits for ready/busy to be high. No write or read strobe is active while ready/busy is low.
- R6: After ready returns, the status opcode is followed by exactly one read strobe. `pass` equals the inverse of status bit 0 captured during that strobe. `done` is high for exactly one cycle.
- R7: If ready/busy is seen low for BUSY_TMO consecutive cycles of the wait, `done` pulses with `timeout`=1 and `pass`=0, and no status cycle is issued. A ready level seen in the expiry cycle takes priority over the timeout.
- R8: Each bus cycle holds its latch and data lines stable for T_SETUP cycles before the strobe falls. The strobe stays low for T_PULSE cycles. The lines stay stable for T_HOLD cycles after the strobe rises.
- R9: Chip-enable is low whenever any latch or strobe is active, and high whenever `busy` is low.
- R10: After reset, chip-enable, write strobe and read strobe are high; both latches, `busy`, `done` and the data output enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one block erase |
| block_addr | input | BLK_W | Block number to erase |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Erase succeeded (valid with done) |
| timeout | output | 1 | Ready/busy wait exceeded its limit (valid with done) |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch |
| nand_ale | output | 1 | Address latch |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data driven to the flash |
| nand_dq_oe | output | 1 | Data output enable |
| nand_dq_i | input | 8 | Data read from the flash |
| nand_rb | input | 1 | Ready (1) / busy (0) from the flash |

## Verification
The return of ready/busy and the expiry of the busy-wait limit can fall in the same cycle. The bench provokes this by sweeping the device's busy length across a window around BUSY_TMO. Erases that are clearly shorter must pass through a status read. Erases that are clearly longer must time out. Inside the window, either result is accepted, but the bytes observed on the bus must match the flags reported: five write cycles and one read for a completed erase, four writes and no read for a timeout.

// File: rtl/nes_pkg.sv
package nes_pkg;

    typedef enum logic [1:0] {
        CYC_CMD  = 2'd0,
        CYC_ADDR = 2'd1,
        CYC_READ = 2'd2
    } cyc_kind_e;

    typedef enum logic [3:0] {
        S_IDLE     = 4'd0,
        S_SETUP    = 4'd1,
        S_ADR_LO   = 4'd2,
        S_ADR_HI   = 4'd3,
        S_CONFIRM  = 4'd4,
        S_SETTLE   = 4'd5,
        S_WAIT_RDY = 4'd6,
        S_STAT_CMD = 4'd7,
        S_STAT_RD  = 4'd8,
        S_FINISH   = 4'd9
    } seq_state_e;

    localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
    localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
    localparam logic [7:0] OP_STATUS      = 8'h70;

endpackage

// File: rtl/nes_bus_cycle.sv
module nes_bus_cycle
    import nes_pkg::*;
#(
    parameter int T_SETUP = 2,
    parameter int T_PULSE = 3,
    parameter int T_HOLD  = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      go,
    input  cyc_kind_e kind,
    input  logic [7:0] wr_byte,
    input  logic [7:0] dq_i,
    output logic      fin,
    output logic [7:0] rd_byte,
    output logic      cle,
    output logic      ale,
    output logic      we_n,
    output logic      re_n,
    output logic [7:0] dq_o,
    output logic      dq_oe
);
    localparam int TM1 = (T_SETUP > T_PULSE) ? T_SETUP : T_PULSE;
    localparam int TMX = (TM1 > T_HOLD) ? TM1 : T_HOLD;
    localparam int CW  = $clog2(TMX + 1);

    typedef enum logic [1:0] {B_IDLE, B_SET, B_STR, B_HLD} bus_ph_e;

    typedef struct packed {
        bus_ph_e   ph;
        logic [CW-1:0] cnt;
        cyc_kind_e kind;
        logic [7:0] dat;
        logic [7:0] rd;
        logic      fin;
    } bus_st_t;

    bus_st_t q, d;

    always_comb begin
        d     = q;
        d.fin = 1'b0;
        case (q.ph)
            B_IDLE: if (go) begin
                d.ph   = B_SET;
                d.cnt  = CW'(T_SETUP - 1);
                d.kind = kind;
                d.dat  = wr_byte;
            end
            B_SET: if (q.cnt == '0) begin
                d.ph  = B_STR;
                d.cnt = CW'(T_PULSE - 1);
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
            B_STR: if (q.cnt == '0) begin
                d.ph  = B_HLD;
                d.cnt = CW'(T_HOLD - 1);
                if (q.kind == CYC_READ) d.rd = dq_i;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
            B_HLD: if (q.cnt == '0) begin
                d.ph  = B_IDLE;
                d.fin = 1'b1;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
            default: d.ph = B_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    logic active;
    assign active  = (q.ph != B_IDLE);
    assign cle     = active && (q.kind == CYC_CMD);
    assign ale     = active && (q.kind == CYC_ADDR);
    assign dq_oe   = active && (q.kind != CYC_READ);
    assign dq_o    = dq_oe ? q.dat : 8'h00;
    assign we_n    = !((q.ph == B_STR) && (q.kind != CYC_READ));
    assign re_n    = !((q.ph == B_STR) && (q.kind == CYC_READ));
    assign fin     = q.fin;
    assign rd_byte = q.rd;
endmodule

// File: rtl/nes_busy_timer.sv
module nes_busy_timer #(
    parameter int LIMIT = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (!run)                         cnt_d = '0;
        else if (cnt_q != TW'(LIMIT - 1)) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run && (cnt_q == TW'(LIMIT - 1));
endmodule

// File: rtl/nand_erase_seq.sv
module nand_erase_seq
    import nes_pkg::*;
#(
    parameter int LAST_BITS = 2,
    parameter int T_SETUP   = 2,
    parameter int T_PULSE   = 3,
    parameter int T_HOLD    = 2,
    parameter int T_WB      = 8,
    parameter int BUSY_TMO  = 100000,
    localparam int BLK_W    = 3 + LAST_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [BLK_W-1:0] block_addr,
    output logic             busy,
    output logic             done,
    output logic             pass,
    output logic             timeout,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [7:0]       nand_dq_o,
    output logic             nand_dq_oe,
    input  logic [7:0]       nand_dq_i,
    input  logic             nand_rb
);
    localparam int WBW = $clog2(T_WB + 1);

    typedef struct packed {
        seq_state_e       st;
        logic [BLK_W-1:0] blk;
        logic             go;
        cyc_kind_e        kind;
        logic [7:0]       wbyte;
        logic [WBW-1:0]   wbc;
        logic             done;
        logic             pass;
        logic             tmo;
        logic             rb_m;
        logic             rb_s;
    } seq_t;

    seq_t q, d;

    logic       cyc_fin;
    logic [7:0] cyc_rd;
    logic       tmo_hit;
    logic       unused_stat_bits;

    assign unused_stat_bits = ^cyc_rd[7:1];

    always_comb begin
        d      = q;
        d.go   = 1'b0;
        d.done = 1'b0;
        d.rb_m = nand_rb;
        d.rb_s = q.rb_m;
        case (q.st)
            S_IDLE: if (start) begin
                d.blk   = block_addr;
                d.st    = S_SETUP;
                d.go    = 1'b1;
                d.kind  = CYC_CMD;
                d.wbyte = OP_ERASE_SETUP;
                d.pass  = 1'b0;
                d.tmo   = 1'b0;
            end
            S_SETUP: if (cyc_fin) begin
                d.st    = S_ADR_LO;
                d.go    = 1'b1;
                d.kind  = CYC_ADDR;
                d.wbyte = {q.blk[2:0], 5'b00000};
            end
            S_ADR_LO: if (cyc_fin) begin
                d.st    = S_ADR_HI;
                d.go    = 1'b1;
                d.kind  = CYC_ADDR;
                d.wbyte = {{(8 - LAST_BITS){1'b0}}, q.blk[BLK_W-1:3]};
            end
            S_ADR_HI: if (cyc_fin) begin
                d.st    = S_CONFIRM;
                d.go    = 1'b1;
                d.kind  = CYC_CMD;
                d.wbyte = OP_ERASE_GO;
            end
            S_CONFIRM: if (cyc_fin) begin
                d.st  = S_SETTLE;
                d.wbc = WBW'(T_WB - 1);
            end
            S_SETTLE: if (q.wbc == '0) d.st = S_WAIT_RDY;
                      else             d.wbc = q.wbc - 1'b1;
            S_WAIT_RDY: if (q.rb_s) begin
                d.st    = S_STAT_CMD;
                d.go    = 1'b1;
                d.kind  = CYC_CMD;
                d.wbyte = OP_STATUS;
            end else if (tmo_hit) begin
                d.st  = S_FINISH;
                d.tmo = 1'b1;
            end
            S_STAT_CMD: if (cyc_fin) begin
                d.st    = S_STAT_RD;
                d.go    = 1'b1;
                d.kind  = CYC_READ;
                d.wbyte = 8'h00;
            end
            S_STAT_RD: if (cyc_fin) begin
                d.st   = S_FINISH;
                d.pass = !cyc_rd[0];
            end
            S_FINISH: begin
                d.done = 1'b1;
                d.st   = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    nes_bus_cycle #(
        .T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD)
    ) u_bus (
        .clk(clk), .rst_n(rst_n), .go(q.go), .kind(q.kind),
        .wr_byte(q.wbyte), .dq_i(nand_dq_i), .fin(cyc_fin), .rd_byte(cyc_rd),
        .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
        .dq_o(nand_dq_o), .dq_oe(nand_dq_oe)
    );

    nes_busy_timer #(.LIMIT(BUSY_TMO)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .run((q.st == S_WAIT_RDY) && !q.rb_s),
        .expired(tmo_hit)
    );

    assign busy      = (q.st != S_IDLE);
    assign nand_ce_n = (q.st == S_IDLE);
    assign done      = q.done;
    assign pass      = q.pass;
    assign timeout   = q.tmo;
endmodule

// File: rtl/nes_checker.sv
module nes_checker #(
    parameter int T_SETUP = 2,
    parameter int T_PULSE = 3,
    parameter int T_HOLD  = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       pass,
    input logic       timeout,
    input logic       nand_ce_n,
    input logic       nand_cle,
    input logic       nand_ale,
    input logic       nand_we_n,
    input logic       nand_re_n,
    input logic [7:0] nand_dq_o,
    input logic       nand_dq_oe,
    input logic       nand_rb
);
    logic [10:0] sig, sig_prev;
    logic [15:0] low_cnt, stab_cnt, hi_cnt;

    assign sig = {nand_cle, nand_ale, nand_dq_oe, nand_dq_o};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_prev <= '0;
            low_cnt  <= '0;
            stab_cnt <= '0;
            hi_cnt   <= 16'hFFFF;
        end else begin
            sig_prev <= sig;
            low_cnt  <= nand_we_n ? '0 : ((low_cnt == 16'hFFFF) ? low_cnt : low_cnt + 1'b1);
            stab_cnt <= (sig != sig_prev) ? '0 : ((stab_cnt == 16'hFFFF) ? stab_cnt : stab_cnt + 1'b1);
            hi_cnt   <= !nand_we_n ? '0 : ((hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 1'b1);
        end
    end

    a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    a_r2_cmd_codes: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(nand_we_n) && nand_cle) |->
        ($past(nand_dq_o) == 8'h60 || $past(nand_dq_o) == 8'hD0 || $past(nand_dq_o) == 8'h70));
    a_r4_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));
    a_r5_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_rb |-> (nand_we_n && nand_re_n));
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r7_tmo_fails: assert property (@(posedge clk) disable iff (!rst_n)
        (done && timeout) |-> !pass);
    a_r8_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nand_we_n) |-> (stab_cnt >= 16'(T_SETUP - 1)));
    a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_we_n) |-> (low_cnt >= 16'(T_PULSE)));
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sig != sig_prev) |-> (hi_cnt >= 16'(T_HOLD)));
    a_r9_ce_low: assert property (@(posedge clk) disable iff (!rst_n)
        (nand_cle || nand_ale || !nand_we_n || !nand_re_n) |-> !nand_ce_n);
endmodule

bind nand_erase_seq nes_checker #(
    .T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .pass(pass), .timeout(timeout), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe), .nand_rb(nand_rb)
);

// File: tb/nand_erase_seq_test.sv
`timescale 1ns/1ps
module nand_erase_seq_test;
    localparam int LB  = 2;
    localparam int BW  = 3 + LB;
    localparam int TS  = 2;
    localparam int TP  = 3;
    localparam int TH  = 2;
    localparam int TWB = 6;
    localparam int TMO = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [BW-1:0] block_addr = '0;
    logic busy, done, pass, timeout;
    logic nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0] nand_dq_o, nand_dq_i;
    logic nand_rb = 1'b1;

    always #4 clk = ~clk;

    nand_erase_seq #(
        .LAST_BITS(LB), .T_SETUP(TS), .T_PULSE(TP), .T_HOLD(TH),
        .T_WB(TWB), .BUSY_TMO(TMO)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .block_addr(block_addr),
        .busy(busy), .done(done), .pass(pass), .timeout(timeout),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o),
        .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i), .nand_rb(nand_rb)
    );

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    // flash model state
    logic [9:0] lg [0:15];
    int   lg_n = 0;
    int   re_n_cnt = 0;
    int   viol_busy = 0;
    int   viol_width = 0;
    int   viol_ce = 0;
    int   arm = 0;
    int   left = 0;
    int   erase_len = 10;
    int   we_low = 0;
    logic [7:0] status_val = 8'h00;
    logic prev_we = 1'b1;
    logic prev_re = 1'b1;

    assign nand_dq_i = !nand_re_n ? status_val : ~status_val;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!nand_we_n) we_low++;
            if (!prev_we && nand_we_n) begin
                if (we_low != TP) viol_width++;
                we_low = 0;
                if (lg_n < 16) lg[lg_n] = {nand_cle, nand_ale, nand_dq_o};
                lg_n++;
                if (nand_cle && nand_dq_o == 8'hD0) arm = 2;
            end
            if (!prev_re && nand_re_n) re_n_cnt++;
            if (!nand_rb && (!nand_we_n || !nand_re_n)) viol_busy++;
            if (!busy && !nand_ce_n) viol_ce++;
            if ((nand_cle || nand_ale || !nand_we_n || !nand_re_n) && nand_ce_n) viol_ce++;
            if (arm > 0) begin
                arm--;
                if (arm == 0) begin nand_rb = 1'b0; left = erase_len; end
            end else if (!nand_rb) begin
                if (left <= 1) nand_rb = 1'b1;
                else left--;
            end
            prev_we = nand_we_n;
            prev_re = nand_re_n;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_adr1(input logic [BW-1:0] b);
        return {b[2:0], 5'b00000};
    endfunction

    function automatic logic [7:0] exp_adr2(input logic [BW-1:0] b);
        return {{(8 - LB){1'b0}}, b[BW-1:3]};
    endfunction

    // mode: 0 expect completion, 1 expect timeout, 2 either (boundary)
    task automatic run_erase(input logic [BW-1:0] blk, input int elen,
                             input logic [7:0] stat, input int mode);
        int cyc;
        bit tmo_seen;
        int exp_n;
        while (!nand_rb) @(negedge clk);
        @(negedge clk);
        lg_n = 0; re_n_cnt = 0; viol_busy = 0; viol_width = 0; viol_ce = 0;
        erase_len = elen; status_val = stat;
        start = 1'b1; block_addr = blk;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R1 busy after start", busy, 1);
        block_addr = ~blk; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
        chk(done == 1'b1, "R6 done seen", done, 1);
        tmo_seen = timeout;
        if (mode == 0) chk(!timeout, "R7 no timeout on short erase", timeout, 0);
        if (mode == 1) chk(timeout, "R7 timeout on long erase", timeout, 1);
        if (tmo_seen) chk(!pass, "R7 pass low on timeout", pass, 0);
        else          chk(pass == !stat[0], "R6 pass from status bit0", pass, !stat[0]);
        chk(busy == 1'b0, "R1 busy low with done", busy, 0);
        @(negedge clk);
        chk(done == 1'b0, "R6 done one cycle", done, 0);
        exp_n = tmo_seen ? 4 : 5;
        chk(lg_n == exp_n, "R2 write cycle count", lg_n, exp_n);
        chk(lg[0] == {2'b10, 8'h60}, "R2 R4 setup opcode", lg[0], {2'b10, 8'h60});
        chk(lg[1] == {2'b01, exp_adr1(blk)}, "R3 R1 address byte one", lg[1], {2'b01, exp_adr1(blk)});
        chk(lg[2] == {2'b01, exp_adr2(blk)}, "R3 R1 address byte two", lg[2], {2'b01, exp_adr2(blk)});
        chk(lg[3] == {2'b10, 8'hD0}, "R2 R4 confirm opcode", lg[3], {2'b10, 8'hD0});
        if (!tmo_seen)
            chk(lg[4] == {2'b10, 8'h70}, "R6 status opcode", lg[4], {2'b10, 8'h70});
        chk(re_n_cnt == (tmo_seen ? 0 : 1), "R6 R7 read strobe count", re_n_cnt, tmo_seen ? 0 : 1);
        chk(viol_busy == 0, "R5 strobe while busy", viol_busy, 0);
        chk(viol_width == 0, "R8 strobe width", viol_width, 0);
        chk(viol_ce == 0, "R9 chip enable", viol_ce, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd2718);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(nand_ce_n == 1'b1, "R10 ce_n", nand_ce_n, 1);
        chk(nand_we_n == 1'b1 && nand_re_n == 1'b1, "R10 strobes", {nand_we_n, nand_re_n}, 3);
        chk(!nand_cle && !nand_ale, "R10 latches", {nand_cle, nand_ale}, 0);
        chk(!busy && !done && !nand_dq_oe, "R10 busy done oe", {busy, done, nand_dq_oe}, 0);

        run_erase('0, 5, 8'hE0, 0);
        run_erase('1, 40, 8'hE0, 0);
        run_erase(5'b10110, 20, 8'hE1, 0);
        run_erase(5'b01001, 2000, 8'hE0, 1);
        run_erase(5'b11100, TMO, 8'hC0, 0);
        for (int k = 0; k <= 30; k += 3)
            run_erase(BW'($urandom), TMO + k, 8'(($urandom % 2) | 8'hE0), 2);
        run_erase(5'b00111, TMO + 60, 8'hE0, 1);
        for (int k = 0; k < 16; k++)
            run_erase(BW'($urandom), 5 + int'($urandom % 250), 8'($urandom), 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule